// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block sits behind the serial port of a NOR flash device and turns erase commands into erase requests for the array. It watches the chip-select, serial clock and serial data lines in SPI mode 0, oversampled by the core clock. It counts the bits shifted in during each select period and acts only at the moment chip-select is released. A sector erase carries a 3-byte or 4-byte address, and the sector index comes from the address bits at and above the 256 KiB boundary. A whole-array erase carries no address.

An erase goes ahead only when an earlier write-enable command has armed the enable latch, and only when chip-select is released exactly after the last address or opcode bit. It is also subject to the protection settings: the 3-bit protected-range field, and two per-sector lock masks, one persistent and one dynamic. An accepted command emits a one-cycle strobe, either with the sector index or with a per-sector skip mask. It also runs an internal busy timer whose length stands in for the erase time. The busy flag, the enable latch and the erase-error flag are brought out as separate status bits.

The controller has three states. In IDLE it decodes each completed command. The transition IDLE to SECT_BUSY is taken on an accepted sector erase, and IDLE to BULK_BUSY on an accepted whole-array erase. Each busy state returns to IDLE when its timer expires. Refused, ignored or discarded commands leave the controller in IDLE.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Opcode D8h is a sector erase with 32 total bits (opcode plus 3 address bytes) when `addr4_mode`=0, and with 40 total bits when `addr4_mode`=1. Opcode DCh is a sector erase with 40 total bits in either mode. `sect_idx` is address bits [23:18], and `sect_stb` is high for exactly one cycle.
- R2: Opcodes 60h and C7h are a whole-array erase when exactly 8 bits were shifted. The block then pulses `bulk_stb` for one cycle.
- R3: Opcode 06h with exactly 8 bits sets `wel`. An erase command while `wel`=0 is ignored: no strobe, and `wel` and `err` stay unchanged.
- R4: If chip-select rises after any bit count other than the one required by the opcode, the command is discarded: no strobe and no status change, so `wel` remains 1.
- R5: `busy` goes to 1 on the cycle after the chip-select release that starts an erase. It stays at 1 for SECT_CYC cycles for a sector erase, or BULK_CYC cycles for a whole-array erase, then returns to 0. `wel` clears on the same edge.
- R6: A sector erase aimed at a sector covered by the protected range, by its `ppb_lock` bit or by its `dyb_lock` bit (1 = locked) is not performed. It sets `err` and clears `wel`.
- R7: A whole-array erase while `bp_range`≠0 is not performed. It clears `wel` and leaves `err` unchanged.
- R8: An accepted whole-array erase presents `bulk_skip` = `ppb_lock | dyb_lock` and does not set `err`.
- R9: While `busy`=1, every incoming command (erase or 06h) is ignored.
- R10: `bp_range` value 0 protects no sectors and value 7 protects all sectors. A value v from 1 to 6 protects the top N_SECT>>(7−v) sectors.
- R11: After reset, `busy`, `wel`, `err` and both strobes are 0. An accepted erase clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, data captured on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| addr4_mode | input | 1 | 1 selects 4-byte addressing for D8h |
| bp_range | input | 3 | Protected-range field |
| ppb_lock | input | N_SECT | Persistent per-sector lock |
| dyb_lock | input | N_SECT | Dynamic per-sector lock |
| sect_stb | output | 1 | One-cycle sector erase request |
| sect_idx | output | log2(N_SECT) | Sector to erase |
| bulk_stb | output | 1 | One-cycle whole-array erase request |
| bulk_skip | output | N_SECT | Sectors to leave untouched in a whole-array erase |
| busy | output | 1 | Erase in progress |
| wel | output | 1 | Write enable latch |
| err | output | 1 | Erase error flag |

## Verification
The assertions check the following on every cycle:
- a strobe lasts one cycle and is never issued while an erase is already running;
- a rising `busy` finds `wel` set, and a falling `busy` clears it;
- `err` only rises when no erase starts;
- the whole-array skip mask matches the lock inputs;
- a whole-array erase only starts with the protected-range field at zero.

Only the bench scenarios can show the rest. That covers bit-count exactness for each opcode and addressing mode, the sector index extracted from the address, and the protected-range boundaries. It also covers the exact busy duration, and the different refusal behaviour of the two erase kinds.

// File: rtl/fec_pkg.sv
package fec_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_SE3   = 8'hD8;
    localparam logic [7:0] OP_SE4   = 8'hDC;
    localparam logic [7:0] OP_BE_A  = 8'h60;
    localparam logic [7:0] OP_BE_B  = 8'hC7;
    localparam int SECT_LSB = 18;   // 256 KiB sector boundary

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SECT_BUSY = 2'd1,
        ST_BULK_BUSY = 2'd2
    } fec_state_e;
endpackage

// File: rtl/fec_spi_rx.sv
module fec_spi_rx (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        si,
    output logic [5:0]  bit_cnt,
    output logic [7:0]  opcode,
    output logic [31:0] shift_q,
    output logic        cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            opcode  <= '0;
            shift_q <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sck && !sck_q) begin
                shift_q <= {shift_q[30:0], si};
                if (bit_cnt != 6'h3F) bit_cnt <= bit_cnt + 6'd1;
                if (bit_cnt == 6'd7)  opcode  <= {shift_q[6:0], si};
            end
        end
    end

    assign cs_rise = cs_n && !cs_q;
endmodule

// File: rtl/fec_protect.sv
module fec_protect #(
    parameter int N_SECT = 64,
    parameter int IDX_W  = $clog2(N_SECT)
) (
    input  logic [2:0]        bp_range,
    input  logic [N_SECT-1:0] ppb_lock,
    input  logic [N_SECT-1:0] dyb_lock,
    input  logic [IDX_W-1:0]  idx,
    output logic              sect_blocked,
    output logic              bp_clear
);
    localparam logic [IDX_W:0] NS = (IDX_W+1)'(N_SECT);
    logic [IDX_W:0] prot_cnt;

    always_comb begin
        if (bp_range == 3'd0)      prot_cnt = '0;
        else if (bp_range == 3'd7) prot_cnt = NS;
        else                       prot_cnt = NS >> (3'd7 - bp_range);
    end

    assign sect_blocked = ({1'b0, idx} >= (NS - prot_cnt)) || ppb_lock[idx] || dyb_lock[idx];
    assign bp_clear     = (bp_range == 3'd0);
endmodule

// File: rtl/fec_erase_fsm.sv
module fec_erase_fsm
    import fec_pkg::*;
#(
    parameter int N_SECT   = 64,
    parameter int IDX_W    = $clog2(N_SECT),
    parameter int SECT_CYC = 50,
    parameter int BULK_CYC = 200,
    parameter int TMR_W    = $clog2(BULK_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic [5:0]        bit_cnt,
    input  logic [7:0]        opcode,
    input  logic              addr4_mode,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              sect_blocked,
    input  logic              bp_clear,
    input  logic [N_SECT-1:0] lock_any,
    output logic              sect_stb,
    output logic [IDX_W-1:0]  sect_idx,
    output logic              bulk_stb,
    output logic [N_SECT-1:0] bulk_skip,
    output logic              busy,
    output logic              wel,
    output logic              err
);
    localparam logic [TMR_W-1:0] SECT_LOAD = TMR_W'(SECT_CYC - 1);
    localparam logic [TMR_W-1:0] BULK_LOAD = TMR_W'(BULK_CYC - 1);

    fec_state_e state, state_nx;
    logic [TMR_W-1:0] tmr;
    logic is_wren, is_se, is_be, go_se, go_be;

    assign is_wren = (opcode == OP_WREN) && (bit_cnt == 6'd8);
    assign is_se   = ((opcode == OP_SE3) && (bit_cnt == (addr4_mode ? 6'd40 : 6'd32)))
                  || ((opcode == OP_SE4) && (bit_cnt == 6'd40));
    assign is_be   = ((opcode == OP_BE_A) || (opcode == OP_BE_B)) && (bit_cnt == 6'd8);
    assign go_se   = cs_rise && wel && is_se && !sect_blocked;
    assign go_be   = cs_rise && wel && is_be && bp_clear;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_se)      state_nx = ST_SECT_BUSY;
                else if (go_be) state_nx = ST_BULK_BUSY;
            end
            ST_SECT_BUSY, ST_BULK_BUSY: begin
                if (tmr == '0) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr       <= '0;
            sect_stb  <= 1'b0;
            bulk_stb  <= 1'b0;
            sect_idx  <= '0;
            bulk_skip <= '0;
            wel       <= 1'b0;
            err       <= 1'b0;
        end else begin
            sect_stb <= 1'b0;
            bulk_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cs_rise) begin
                        if (is_wren) begin
                            wel <= 1'b1;
                        end else if (wel && is_se) begin
                            if (sect_blocked) begin
                                err <= 1'b1;
                                wel <= 1'b0;
                            end else begin
                                err      <= 1'b0;
                                sect_stb <= 1'b1;
                                sect_idx <= idx_in;
                                tmr      <= SECT_LOAD;
                            end
                        end else if (wel && is_be) begin
                            if (!bp_clear) begin
                                wel <= 1'b0;
                            end else begin
                                err       <= 1'b0;
                                bulk_stb  <= 1'b1;
                                bulk_skip <= lock_any;
                                tmr       <= BULK_LOAD;
                            end
                        end
                    end
                end
                ST_SECT_BUSY, ST_BULK_BUSY: begin
                    if (tmr == '0) wel <= 1'b0;
                    else           tmr <= tmr - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
    parameter int N_SECT   = 64,
    parameter int SECT_CYC = 50,
    parameter int BULK_CYC = 200,
    parameter int IDX_W    = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              addr4_mode,
    input  logic [2:0]        bp_range,
    input  logic [N_SECT-1:0] ppb_lock,
    input  logic [N_SECT-1:0] dyb_lock,
    output logic              sect_stb,
    output logic [IDX_W-1:0]  sect_idx,
    output logic              bulk_stb,
    output logic [N_SECT-1:0] bulk_skip,
    output logic              busy,
    output logic              wel,
    output logic              err
);
    localparam int IDX_LSB = fec_pkg::SECT_LSB;

    logic [5:0]       bit_cnt;
    logic [7:0]       opcode;
    logic [31:0]      shift_q;
    logic             cs_rise;
    logic             sect_blocked;
    logic             bp_clear;
    logic [IDX_W-1:0] idx_in;

    assign idx_in = shift_q[IDX_LSB +: IDX_W];

    fec_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .bit_cnt(bit_cnt), .opcode(opcode), .shift_q(shift_q), .cs_rise(cs_rise)
    );

    fec_protect #(.N_SECT(N_SECT), .IDX_W(IDX_W)) u_prot (
        .bp_range(bp_range), .ppb_lock(ppb_lock), .dyb_lock(dyb_lock),
        .idx(idx_in), .sect_blocked(sect_blocked), .bp_clear(bp_clear)
    );

    fec_erase_fsm #(
        .N_SECT(N_SECT), .IDX_W(IDX_W), .SECT_CYC(SECT_CYC), .BULK_CYC(BULK_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
        .opcode(opcode), .addr4_mode(addr4_mode), .idx_in(idx_in),
        .sect_blocked(sect_blocked), .bp_clear(bp_clear),
        .lock_any(ppb_lock | dyb_lock),
        .sect_stb(sect_stb), .sect_idx(sect_idx), .bulk_stb(bulk_stb),
        .bulk_skip(bulk_skip), .busy(busy), .wel(wel), .err(err)
    );
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
    parameter int N_SECT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bp_range,
    input logic [N_SECT-1:0] ppb_lock,
    input logic [N_SECT-1:0] dyb_lock,
    input logic              sect_stb,
    input logic              bulk_stb,
    input logic [N_SECT-1:0] bulk_skip,
    input logic              busy,
    input logic              wel,
    input logic              err
);
    p_sect_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sect_stb |=> !sect_stb);
    p_bulk_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_stb |=> !bulk_stb);
    p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);
    p_end_clears_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_stb || bulk_stb) |-> busy);
    p_err_refusal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
    p_bulk_bp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_stb |-> ($past(bp_range) == 3'd0));
    p_bulk_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_stb |-> (bulk_skip == ($past(ppb_lock) | $past(dyb_lock))));
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !(sect_stb || bulk_stb));
    p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sect_stb && bulk_stb));
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.N_SECT(N_SECT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bp_range(bp_range), .ppb_lock(ppb_lock),
    .dyb_lock(dyb_lock), .sect_stb(sect_stb), .bulk_stb(bulk_stb),
    .bulk_skip(bulk_skip), .busy(busy), .wel(wel), .err(err)
);

// File: tb/flash_erase_ctrl_bench.sv
`timescale 1ns/1ps
module flash_erase_ctrl_bench;
    localparam int N_SECT = 64;
    localparam int SC     = 20;
    localparam int BC     = 400;

    typedef struct packed {
        logic        wren;
        logic [7:0]  op;
        logic [31:0] addr;
        logic [5:0]  nb;
        logic        ext;
        logic [2:0]  bp;
        logic        pp_on;
        logic [5:0]  pp_idx;
        logic        x_se;
        logic        x_be;
        logic        x_err;
        logic        x_wel;
        logic [5:0]  x_idx;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{1'b1, 8'hD8, 32'h000C_0000, 6'd32, 1'b0, 3'd0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd3},
        '{1'b1, 8'hD8, 32'h00FC_0000, 6'd40, 1'b1, 3'd0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd63},
        '{1'b1, 8'hDC, 32'h0714_0000, 6'd40, 1'b0, 3'd0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd5},
        '{1'b0, 8'hD8, 32'h000C_0000, 6'd32, 1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        '{1'b1, 8'hD8, 32'h000C_0000, 6'd31, 1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
        '{1'b1, 8'hD8, 32'h00FC_0000, 6'd32, 1'b0, 3'd1, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        '{1'b1, 8'hD8, 32'h0028_0000, 6'd32, 1'b0, 3'd0, 1'b1, 6'd10, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        '{1'b1, 8'hC7, 32'h0000_0000, 6'd8,  1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'd0},
        '{1'b1, 8'h60, 32'h0000_0000, 6'd8,  1'b0, 3'd2, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        '{1'b1, 8'h60, 32'h0000_0000, 6'd9,  1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
        '{1'b1, 8'hDC, 32'h000C_0000, 6'd32, 1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
        '{1'b1, 8'hD8, 32'h000C_0000, 6'd40, 1'b0, 3'd0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
        '{1'b1, 8'hD8, 32'h0000_0000, 6'd32, 1'b0, 3'd7, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        '{1'b1, 8'hD8, 32'h007C_0000, 6'd32, 1'b0, 3'd6, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd31}
    };

    logic clk = 1'b0;
    logic rst_n, sck, cs_n, si, addr4_mode;
    logic [2:0] bp_range;
    logic [N_SECT-1:0] ppb_lock, dyb_lock, bulk_skip;
    logic sect_stb, bulk_stb, busy, wel, err;
    logic [5:0] sect_idx;

    int checks = 0;
    int failures = 0;
    int se_seen = 0;
    int be_seen = 0;
    logic [5:0] last_idx = '0;
    logic [N_SECT-1:0] last_skip = '0;

    always #2.5 clk = ~clk;

    flash_erase_ctrl #(.N_SECT(N_SECT), .SECT_CYC(SC), .BULK_CYC(BC)) u_flash_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .addr4_mode(addr4_mode), .bp_range(bp_range), .ppb_lock(ppb_lock),
        .dyb_lock(dyb_lock), .sect_stb(sect_stb), .sect_idx(sect_idx),
        .bulk_stb(bulk_stb), .bulk_skip(bulk_skip), .busy(busy), .wel(wel), .err(err)
    );

    always @(posedge clk) begin
        if (sect_stb) begin se_seen <= se_seen + 1; last_idx <= sect_idx; end
        if (bulk_stb) begin be_seen <= be_seen + 1; last_skip <= bulk_skip; end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [31:0] addr, input int nb);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < nb; i++) begin
            si  = (i < 8) ? op[7-i] : addr[nb-1-i];
            sck = 1'b0;
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
        end
        sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic gap();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int se0, be0;
        addr4_mode = 1'b0; bp_range = '0; ppb_lock = '0; dyb_lock = '0;
        do_reset();
        // R11 reset state
        chk(!busy && !wel && !err && !sect_stb && !bulk_stb, "R11 reset state",
            {busy, wel, err, sect_stb, bulk_stb}, 0);

        // table walk: R1 R2 R3 R4 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            do_reset();
            addr4_mode = VT[v].ext;
            bp_range   = VT[v].bp;
            ppb_lock   = '0;
            dyb_lock   = '0;
            if (VT[v].pp_on) ppb_lock[VT[v].pp_idx] = 1'b1;
            se0 = se_seen; be0 = be_seen;
            if (VT[v].wren) begin send_cmd(8'h06, 32'h0, 8); gap(); end
            send_cmd(VT[v].op, VT[v].addr, VT[v].nb);
            gap();
            wait_idle();
            gap();
            chk((se_seen - se0) == int'(VT[v].x_se), $sformatf("R1/R4 vec%0d sector strobe", v),
                se_seen - se0, VT[v].x_se);
            chk((be_seen - be0) == int'(VT[v].x_be), $sformatf("R2/R7 vec%0d bulk strobe", v),
                be_seen - be0, VT[v].x_be);
            chk(err == VT[v].x_err, $sformatf("R6/R10 vec%0d err", v), err, VT[v].x_err);
            chk(wel == VT[v].x_wel, $sformatf("R3/R4 vec%0d wel", v), wel, VT[v].x_wel);
            if (VT[v].x_se)
                chk(last_idx == VT[v].x_idx, $sformatf("R1 vec%0d sector index", v),
                    last_idx, VT[v].x_idx);
        end

        // R5 busy duration for a sector erase
        do_reset();
        addr4_mode = 1'b0; bp_range = '0; ppb_lock = '0; dyb_lock = '0;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hD8, 32'h0008_0000, 32);
        @(negedge clk);
        chk(busy == 1'b1, "R5 busy on first cycle", busy, 1);
        repeat (SC - 1) @(negedge clk);
        chk(busy == 1'b1 && wel == 1'b1, "R5 busy on last cycle", {busy, wel}, 3);
        @(negedge clk);
        chk(busy == 1'b0 && wel == 1'b0, "R5 busy and wel clear", {busy, wel}, 0);

        // R9 commands ignored while busy
        do_reset();
        se0 = se_seen; be0 = be_seen;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hC7, 32'h0, 8); gap();
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hD8, 32'h0004_0000, 32); gap();
        chk(busy == 1'b1, "R9 still busy during probes", busy, 1);
        wait_idle(); gap();
        chk(se_seen == se0, "R9 no sector erase while busy", se_seen - se0, 0);
        chk(be_seen - be0 == 1, "R9 one bulk erase", be_seen - be0, 1);
        chk(wel == 1'b0, "R9 wren ignored while busy", wel, 0);

        // R8 skip mask
        do_reset();
        ppb_lock = '0; dyb_lock = '0;
        ppb_lock[4] = 1'b1; dyb_lock[9] = 1'b1;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'h60, 32'h0, 8); gap();
        wait_idle(); gap();
        chk(last_skip == ((64'd1 << 4) | (64'd1 << 9)), "R8 skip mask", last_skip,
            (64'd1 << 4) | (64'd1 << 9));
        chk(err == 1'b0, "R8 no err on skip", err, 0);

        // R6 dynamic lock, then R7 err unchanged, then R11 err cleared
        do_reset();
        ppb_lock = '0; dyb_lock = '0; dyb_lock[7] = 1'b1;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hD8, 32'h001C_0000, 32); gap();
        chk(err == 1'b1 && wel == 1'b0, "R6 dyb lock refusal", {err, wel}, 2);
        be0 = be_seen;
        bp_range = 3'd3;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hC7, 32'h0, 8); gap();
        chk(err == 1'b1 && wel == 1'b0 && be_seen == be0, "R7 err unchanged",
            {err, wel}, 2);
        bp_range = 3'd0;
        send_cmd(8'h06, 32'h0, 8); gap();
        send_cmd(8'hD8, 32'h0020_0000, 32); gap();
        chk(err == 1'b0 && busy == 1'b1, "R11 accepted erase clears err", {err, busy}, 1);
        wait_idle(); gap();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule